// File: doc/BRIEF.md
# Dual-Word Programmable Clock Divider

This block divides its clock by a programmable ratio. At its core is a down counter that counts one step on each rising edge while counting is enabled. Whenever the counter sits at zero, the next enabled edge reloads it with a divide word. Two divide words are kept in two holding registers, A and B. A select input picks which one supplies the reload value. Each register has its own load strobe and its own input word, so software-free hardware such as a dual-modulus prescaler controller can keep both ratios ready and swap between them with one bit.

Each time the counter is found at zero on an enabled edge, the block raises its terminal-count output. That output passes through one extra flip-flop before it leaves the block, so it is glitch-free and its timing is set by a single clock edge. With a stored word M the output pulses once every M+1 enabled cycles. A word of zero keeps the output high, which is divide-by-one.

Top module: `dualword_divider`

## Requirements
- R1: While `rst` is high (synchronous, active high), the output `tc_out` is low and both holding registers and the counter are cleared. After reset is released with `cnt_en` high and no load, `tc_out` is high on every cycle, because a stored word of zero divides by one.
- R2: With `sel_b` = 0, the reload value comes from register A. With a stored value M, the rising edges of `tc_out` are M+1 clock cycles apart.
- R3: With `sel_b` = 1, the reload value comes from register B. With a stored value M, the rising edges of `tc_out` are M+1 clock cycles apart.
- R4: For a stored value M of 1 or more, each `tc_out` pulse lasts exactly one clock cycle.
- R5: A holding register takes its input word on every rising edge where its load strobe (active high) is high, so it ends up with the last word present while the strobe was held. When the strobe is low, changes on the word have no effect on the divide ratio.
- R6: `sel_b` and the register contents are used only at the reload point, which is the edge where the counter leaves zero. A change made in the middle of a count takes effect from the next reload and does not shorten or lengthen the count in progress.
- R7: On edges where `cnt_en` is low, the counter holds its value and `tc_out` stays low. Each disabled cycle adds one cycle to the interval in which it falls, including when the counter is paused at zero.
- R8: `tc_out` is a registered signal. It is high in the cycle after an enabled edge at which the counter stood at zero. After reset is released, the first pulse appears one cycle after the first enabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything is on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable, active high |
| sel_b | input | 1 | Reload source: 0 = register A, 1 = register B |
| load_a | input | 1 | Load strobe for register A, active high |
| load_b | input | 1 | Load strobe for register B, active high |
| word_a | input | 8 | Input word for register A |
| word_b | input | 8 | Input word for register B |
| tc_out | output | 1 | Registered terminal-count pulse |

## Verification
The divide ratio is swept through every value from 0 to 20 on register A and then on register B. Each pulse spacing is compared with M+1, and a spacing of one cycle exposes a pulse wider than one cycle. Changes to the select line and to the register contents are made in the middle of a count: an interval that stays at the old length and then switches to the new one shows that the select is sampled only at reload rather than straight away. Pauses of the enable are placed both during a count and while the counter is at zero, which separates "hold and extend the interval" from "drop or fire a pulse". A held load with a changing word, and then a reset in the middle of a run, complete the set.

// File: rtl/dwdiv_pkg.sv
package dwdiv_pkg;

   // Encoding of the reload-source select input.
   typedef enum logic {
      WORD_A = 1'b0,
      WORD_B = 1'b1
   } word_sel_e;

   // Number of holding registers the select line chooses between.
   localparam int NUM_WORDS = 2;

   // Index width needed to address the holding registers.
   localparam int SEL_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

endpackage

// File: rtl/dwdiv_modreg.sv
module dwdiv_modreg #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [WIDTH-1:0] word,
   output logic [WIDTH-1:0] value
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("dwdiv_modreg: WIDTH must be at least 1");
      end
   endgenerate

   // Transparent-while-high behaviour done synchronously: the register
   // captures on each edge where the strobe is high.
   always_ff @(posedge clk) begin
      if (rst) begin
         value <= '0;
      end else if (load) begin
         value <= word;
      end
   end

endmodule

// File: rtl/dwdiv_downcnt.sv
module dwdiv_downcnt #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [WIDTH-1:0] reload_val,
   output logic [WIDTH-1:0] count,
   output logic             zero_hit
);

   localparam logic [WIDTH-1:0] ZERO = '0;
   localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("dwdiv_downcnt: WIDTH must be at least 2");
      end
   endgenerate

   logic at_zero;
   logic [WIDTH-1:0] count_nx;

   assign at_zero  = (count == ZERO);
   assign zero_hit = en && at_zero;

   always_comb begin
      count_nx = count;
      if (en) begin
         if (at_zero) begin
            count_nx = reload_val;
         end else begin
            count_nx = count - ONE;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         count <= ZERO;
      end else begin
         count <= count_nx;
      end
   end

endmodule

// File: rtl/dwdiv_tcstage.sv
module dwdiv_tcstage #(
   parameter bit RETIME = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic hit,
   output logic tc
);

   generate
      if (RETIME) begin : g_retimed
         logic tc_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               tc_q <= 1'b0;
            end else begin
               tc_q <= hit;
            end
         end
         assign tc = tc_q;
      end else begin : g_direct
         assign tc = hit && !rst;
      end
   endgenerate

endmodule

// File: rtl/dualword_divider.sv
module dualword_divider
   import dwdiv_pkg::*;
#(
   parameter int WIDTH  = 8,
   parameter bit RETIME = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cnt_en,
   input  logic             sel_b,
   input  logic             load_a,
   input  logic             load_b,
   input  logic [WIDTH-1:0] word_a,
   input  logic [WIDTH-1:0] word_b,
   output logic             tc_out
);

   generate
      if (WIDTH < 2 || WIDTH > 32) begin : g_bad_width
         $error("dualword_divider: WIDTH must be within 2..32");
      end
      if (NUM_WORDS != 2) begin : g_bad_words
         $error("dualword_divider: exactly two holding registers expected");
      end
   endgenerate

   logic [WIDTH-1:0] word_in  [NUM_WORDS];
   logic             load_in  [NUM_WORDS];
   logic [WIDTH-1:0] mod_val  [NUM_WORDS];
   logic [WIDTH-1:0] reload_val;
   logic [WIDTH-1:0] count_q;
   logic             zero_hit;
   word_sel_e        src_sel;

   assign word_in[0] = word_a;
   assign word_in[1] = word_b;
   assign load_in[0] = load_a;
   assign load_in[1] = load_b;

   generate
      for (genvar gi = 0; gi < NUM_WORDS; gi++) begin : g_word
         dwdiv_modreg #(.WIDTH(WIDTH)) u_reg (
            .clk   (clk),
            .rst   (rst),
            .load  (load_in[gi]),
            .word  (word_in[gi]),
            .value (mod_val[gi])
         );
      end
   endgenerate

   assign src_sel    = word_sel_e'(sel_b);
   assign reload_val = (src_sel == WORD_B) ? mod_val[1] : mod_val[0];

   dwdiv_downcnt #(.WIDTH(WIDTH)) u_cnt (
      .clk        (clk),
      .rst        (rst),
      .en         (cnt_en),
      .reload_val (reload_val),
      .count      (count_q),
      .zero_hit   (zero_hit)
   );

   dwdiv_tcstage #(.RETIME(RETIME)) u_tc (
      .clk (clk),
      .rst (rst),
      .hit (zero_hit),
      .tc  (tc_out)
   );

endmodule

// File: rtl/dualword_divider_chk.sv
module dualword_divider_chk #(
   parameter int WIDTH  = 8,
   parameter bit RETIME = 1'b1
) (
   input logic             clk,
   input logic             rst,
   input logic             cnt_en,
   input logic             sel_b,
   input logic             load_a,
   input logic             load_b,
   input logic [WIDTH-1:0] word_a,
   input logic [WIDTH-1:0] word_b,
   input logic [WIDTH-1:0] count,
   input logic [WIDTH-1:0] val_a,
   input logic [WIDTH-1:0] val_b,
   input logic             tc_out
);

   // R1: reset clears the counter and the output on the next edge
   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (count == '0 && !tc_out && val_a == '0 && val_b == '0));

   // R2: counting steps down by one
   assert_decrement_R2: assert property (@(posedge clk) disable iff (rst)
      (cnt_en && count != '0) |=> (count == $past(count) - 1'b1));

   // R5: load captures, otherwise keep
   assert_load_a_R5: assert property (@(posedge clk) disable iff (rst)
      load_a |=> (val_a == $past(word_a)));
   assert_keep_a_R5: assert property (@(posedge clk) disable iff (rst)
      !load_a |=> $stable(val_a));
   assert_load_b_R5: assert property (@(posedge clk) disable iff (rst)
      load_b |=> (val_b == $past(word_b)));
   assert_keep_b_R5: assert property (@(posedge clk) disable iff (rst)
      !load_b |=> $stable(val_b));

   // R6: reload takes the word chosen by the select at the reload edge
   assert_reload_src_R6: assert property (@(posedge clk) disable iff (rst)
      (cnt_en && count == '0) |=>
         (count == ($past(sel_b) ? $past(val_b) : $past(val_a))));

   // R7: disabled edges hold the counter and emit no pulse
   assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !cnt_en |=> $stable(count));

   generate
      if (RETIME) begin : g_retime_chk
         assert_no_tc_idle_R7: assert property (@(posedge clk) disable iff (rst)
            !cnt_en |=> !tc_out);

         // R8: registered pulse follows an enabled zero by one cycle
         assert_tc_after_zero_R8: assert property (@(posedge clk) disable iff (rst)
            (cnt_en && count == '0) |=> tc_out);
         assert_tc_only_after_zero_R8: assert property (@(posedge clk) disable iff (rst)
            !(cnt_en && count == '0) |=> !tc_out);
      end
   endgenerate

endmodule

bind dualword_divider dualword_divider_chk #(.WIDTH(WIDTH), .RETIME(RETIME)) u_chk (
   .clk    (clk),
   .rst    (rst),
   .cnt_en (cnt_en),
   .sel_b  (sel_b),
   .load_a (load_a),
   .load_b (load_b),
   .word_a (word_a),
   .word_b (word_b),
   .count  (count_q),
   .val_a  (mod_val[0]),
   .val_b  (mod_val[1]),
   .tc_out (tc_out)
);

// File: tb/dualword_divider_test.sv
module dualword_divider_test;

   logic       clk = 1'b0;
   logic       rst;
   logic       cnt_en;
   logic       sel_b;
   logic       load_a;
   logic       load_b;
   logic [7:0] word_a;
   logic [7:0] word_b;
   logic       tc_out;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   dualword_divider uut (
      .clk    (clk),
      .rst    (rst),
      .cnt_en (cnt_en),
      .sel_b  (sel_b),
      .load_a (load_a),
      .load_b (load_b),
      .word_a (word_a),
      .word_b (word_b),
      .tc_out (tc_out)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Count negedges until tc_out is seen high.
   task automatic wait_tc(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!tc_out && n < 1000);
   endtask

   task automatic put_a(input int v);
      load_a = 1'b1;
      word_a = v[7:0];
      @(negedge clk);
      load_a = 1'b0;
   endtask

   task automatic put_b(input int v);
      load_b = 1'b1;
      word_b = v[7:0];
      @(negedge clk);
      load_b = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int n;
      rst = 1'b1; cnt_en = 1'b1; sel_b = 1'b0;
      load_a = 1'b0; load_b = 1'b0; word_a = 8'd0; word_b = 8'd0;
      repeat (3) @(negedge clk);
      check(tc_out == 1'b0, "R1 tc low in reset", tc_out, 0);
      rst = 1'b0;
      // R8: first pulse one cycle after first enabled edge; R1: divide-by-one
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check(tc_out == 1'b1, (i == 0) ? "R8 first pulse" : "R1 divide by one", tc_out, 1);
      end

      // R2: sweep register A
      sel_b = 1'b0;
      for (int m = 0; m <= 20; m++) begin
         put_a(m);
         wait_tc(n);
         for (int k = 0; k < 3; k++) begin
            wait_tc(n);
            check(n == m + 1, (m == 0) ? "R2 spacing" : "R2/R4 spacing and width", n, m + 1);
         end
      end

      // R3: sweep register B
      sel_b = 1'b1;
      for (int m = 0; m <= 20; m++) begin
         put_b(m);
         wait_tc(n);
         for (int k = 0; k < 3; k++) begin
            wait_tc(n);
            check(n == m + 1, "R3 spacing", n, m + 1);
         end
      end

      // R6: select switched mid-count
      sel_b = 1'b0;
      put_a(5);
      put_b(9);
      wait_tc(n);
      wait_tc(n);
      n = 0;
      repeat (2) begin @(negedge clk); n++; end
      sel_b = 1'b1;
      begin int r; wait_tc(r); n += r; end
      check(n == 6, "R6 select change no truncation", n, 6);
      wait_tc(n);
      check(n == 10, "R6 select applied at reload", n, 10);

      // R6: register A rewritten mid-count while selected
      sel_b = 1'b0;
      wait_tc(n);
      wait_tc(n);
      n = 1;
      put_a(2);
      begin int r; wait_tc(r); n += r; end
      check(n == 6, "R6 register change no truncation", n, 6);
      wait_tc(n);
      check(n == 3, "R6 new word from reload", n, 3);

      // R5: held strobe, last word wins; later word changes ignored
      load_a = 1'b1; word_a = 8'd3;
      @(negedge clk);
      word_a = 8'd7;
      @(negedge clk);
      load_a = 1'b0; word_a = 8'd12;
      wait_tc(n);
      for (int k = 0; k < 2; k++) begin
         wait_tc(n);
         check(n == 8, "R5 held load keeps last word", n, 8);
      end

      // R7: pause in the middle of a count
      put_a(6);
      wait_tc(n);
      n = 0;
      repeat (2) begin @(negedge clk); n++; end
      cnt_en = 1'b0;
      repeat (4) begin
         @(negedge clk); n++;
         check(tc_out == 1'b0, "R7 no pulse while paused", tc_out, 0);
      end
      cnt_en = 1'b1;
      begin int r; wait_tc(r); n += r; end
      check(n == 11, "R7 pause extends interval", n, 11);

      // R7: pause while the counter sits at zero
      put_a(3);
      wait_tc(n);
      n = 0;
      repeat (3) begin @(negedge clk); n++; end
      cnt_en = 1'b0;
      repeat (5) begin
         @(negedge clk); n++;
         check(tc_out == 1'b0, "R7 zero pause no pulse", tc_out, 0);
      end
      cnt_en = 1'b1;
      begin int r; wait_tc(r); n += r; end
      check(n == 9, "R7 zero pause extends interval", n, 9);

      // R1: reset in the middle of a run clears the registers
      put_a(9);
      put_b(9);
      repeat (4) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check(tc_out == 1'b0, "R1 mid-run reset", tc_out, 0);
      rst = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check(tc_out == 1'b1, "R1 registers cleared", tc_out, 1);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule